// File: doc/BRIEF.md
# Pattern Fetch Address Sequencer

This block produces the video-memory address stream of a tile-based picture generator across one rendering scanline, one dot at a time. On each dot it takes the dot position and decodes it into a fetch type: nametable, attribute, background pattern, discarded sprite-phase nametable, sprite pattern, trailing nametable, or idle. It then forms the 14-bit address for that fetch and raises a strobe on the first dot of each two-dot fetch.

The main point of the block is the exact order of fetches. Background groups, sprite groups, the two-tile prefetch, the trailing nametable reads and the idle dot at the end of the line all sit at the same dots as in the real fetch pattern. For that reason, address bit 12 toggles on the dedicated output exactly as a downstream edge detector would see it. The caller supplies the scroll-derived nametable pointer, the background tile index and its fine row, and the per-slot sprite tiles and rows. All outputs are registered, so they reflect the dot presented one clock earlier. The block also flags the last dot of the line so that the dot counter can wrap, which shortens the line by one dot on the pre-render line of odd frames.

Top module: `pattern_fetch_seq`

## Requirements
- R1: While reset is held, `vaddr_o`, `fetch_o`, `a12_o` and `line_last_o` are all zero.
- R2: With rendering enabled, `fetch_o` pulses for one clock after each even dot from 0 to 338 and stays low after every odd dot and after dot 340. Every output appears one clock after its dot is presented.
- R3: Dots 0–255 and 320–335 form background groups of 8 dots. At offsets 0, 2, 4 and 6 of a group, the fetches are addressed as follows:
  - offset 0: `0x2000 | nt_ptr`
  - offset 2: attribute `0x23C0 | nt_ptr[11:10]<<10 | nt_ptr[9:7]<<3 | nt_ptr[4:2]`
  - offsets 4 and 6: pattern low and high planes `bg_half<<12 | tile<<4 | plane<<3 | fine_y`
- R4: Dots 256–319 form 8 sprite groups; slot = (dot−256)/8. Offsets 0 and 2 repeat the nametable address `0x2000 | nt_ptr`. In 8x8 mode, offsets 4 and 6 fetch `spr_half<<12 | tile<<4 | plane<<3 | row[2:0]`. Slot i takes its tile from `spr_tile_i[8i+7:8i]` and its row from `spr_row_i[4i+3:4i]`.
- R5: A slot whose `spr_valid_i` bit is 0 fetches tile 0xFF with row 0.
- R6: In 8x16 mode, the pattern half is tile bit 0 and the tile index is `{tile[7:1], row[3]}`, and the row within the tile is `row[2:0]`.
- R7: Dots 336 and 338 start two more nametable fetches at `0x2000 | nt_ptr`.
- R8: `vaddr_o` holds its value on the second dot of a fetch and on the idle dot 340. `a12_o` always equals bit 12 of the address being driven.
- R9: While `render_en_i` is low, no strobe is issued and `vaddr_o` holds its last value.
- R10: `line_last_o` follows dot 340. On a pre-render line with an odd frame and rendering on, it follows dot 339 instead.
- R11: `a12_o` is low throughout every nametable and attribute fetch, including the discarded sprite-phase reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dot_i | input | 9 | Dot position within the line, 0–340 |
| prerender_i | input | 1 | Current line is the pre-render line |
| odd_frame_i | input | 1 | Current frame is odd |
| render_en_i | input | 1 | Rendering enabled |
| bg_half_i | input | 1 | Pattern half used for background tiles |
| spr_half_i | input | 1 | Pattern half used for 8x8 sprites |
| tall_spr_i | input | 1 | 8x16 sprite mode |
| nt_ptr_i | input | 12 | Nametable entry offset for the current tile |
| bg_tile_i | input | 8 | Background tile index |
| fine_y_i | input | 3 | Row within the background tile |
| spr_tile_i | input | 64 | Tile number per sprite slot, 8 bits each |
| spr_row_i | input | 32 | Row within the sprite per slot, 4 bits each |
| spr_valid_i | input | 8 | Slot holds a sprite |
| vaddr_o | output | 14 | Video memory address |
| fetch_o | output | 1 | First dot of a fetch |
| a12_o | output | 1 | Address bit 12 |
| line_last_o | output | 1 | Last dot of the line |

## Verification
The reference model runs whole scanlines with each of these configurations:
- background on the lower half and sprites on the upper half, and the same with the halves swapped; comparing the two separates the background path from the sprite path through bit 12;
- 8x16 mode with odd and even tiles and rows above 7, which shows that the half and the index come from the tile and row rather than from the select bit;
- partly empty sprite slots, which exposes any slot that does not substitute tile 0xFF;
- pre-render lines with the odd-frame flag set and cleared, which checks the early line end;
- a line with rendering switched off partway through, which shows that strobes stop and the address freezes.

The nametable pointer and the tile index change on every dot, so a fetch that samples its inputs on the wrong dot also shows up.

// File: rtl/fetchseq_pkg.sv
package fetchseq_pkg;

    localparam int unsigned VADDR_W    = 14;
    localparam int unsigned NT_W       = 12;
    localparam int unsigned TILE_W     = 8;
    localparam int unsigned FINE_W     = 3;
    localparam int unsigned SROW_W     = 4;
    localparam int unsigned FETCH_DOTS = 2;
    localparam int unsigned GROUP_FETCHES = 4;
    localparam int unsigned GROUP_DOTS = FETCH_DOTS * GROUP_FETCHES;
    localparam int unsigned FD_W       = $clog2(FETCH_DOTS);
    localparam int unsigned STEP_W     = $clog2(GROUP_FETCHES);
    localparam int unsigned GRP_SH     = $clog2(GROUP_DOTS);
    localparam logic [TILE_W-1:0] EMPTY_TILE = 8'hFF;

    typedef enum logic [2:0] {
        FK_IDLE,
        FK_NAME,
        FK_ATTR,
        FK_BG_PAT,
        FK_SPR_DUMMY,
        FK_SPR_PAT
    } fetch_kind_e;

    typedef struct packed {
        logic [VADDR_W-1:0] addr;
        logic               strobe;
        logic               line_last;
    } seq_state_t;

endpackage

// File: rtl/fetchseq_decode.sv
module fetchseq_decode
    import fetchseq_pkg::*;
#(
    parameter int unsigned DOT_W      = 9,
    parameter int unsigned BG_GROUPS  = 32,
    parameter int unsigned SPR_GROUPS = 8,
    parameter int unsigned PRE_GROUPS = 2,
    parameter int unsigned TAIL_FETCH = 2,
    parameter int unsigned IDX_W      = $clog2(SPR_GROUPS)
) (
    input  logic [DOT_W-1:0] dot_i,
    output fetch_kind_e      kind_o,
    output logic             first_o,
    output logic             plane_o,
    output logic [IDX_W-1:0] spr_idx_o
);

    localparam logic [DOT_W-1:0] SPR_START  = DOT_W'(BG_GROUPS * GROUP_DOTS);
    localparam logic [DOT_W-1:0] PRE_START  = DOT_W'((BG_GROUPS + SPR_GROUPS) * GROUP_DOTS);
    localparam logic [DOT_W-1:0] TAIL_START =
        DOT_W'((BG_GROUPS + SPR_GROUPS + PRE_GROUPS) * GROUP_DOTS);
    localparam logic [DOT_W-1:0] TAIL_END   =
        DOT_W'((BG_GROUPS + SPR_GROUPS + PRE_GROUPS) * GROUP_DOTS + TAIL_FETCH * FETCH_DOTS);

    logic [STEP_W-1:0] step;
    logic [DOT_W-1:0]  rel;

    assign step = dot_i[FD_W +: STEP_W];
    assign rel  = dot_i - SPR_START;

    always_comb begin
        kind_o    = FK_IDLE;
        first_o   = (dot_i[FD_W-1:0] == '0);
        plane_o   = step[0];
        spr_idx_o = IDX_W'(rel >> GRP_SH);
        if (dot_i < SPR_START || (dot_i >= PRE_START && dot_i < TAIL_START)) begin
            case (step)
                2'd0:    kind_o = FK_NAME;
                2'd1:    kind_o = FK_ATTR;
                default: kind_o = FK_BG_PAT;
            endcase
        end else if (dot_i < PRE_START) begin
            kind_o = (step < 2'd2) ? FK_SPR_DUMMY : FK_SPR_PAT;
        end else if (dot_i < TAIL_END) begin
            kind_o = FK_NAME;
        end
    end

endmodule

// File: rtl/fetchseq_addr.sv
module fetchseq_addr
    import fetchseq_pkg::*;
#(
    parameter int unsigned NUM_SPR = 8,
    parameter int unsigned IDX_W   = $clog2(NUM_SPR)
) (
    input  fetch_kind_e              kind_i,
    input  logic                     plane_i,
    input  logic [IDX_W-1:0]         spr_idx_i,
    input  logic [NT_W-1:0]          nt_ptr_i,
    input  logic [TILE_W-1:0]        bg_tile_i,
    input  logic [FINE_W-1:0]        fine_y_i,
    input  logic                     bg_half_i,
    input  logic                     spr_half_i,
    input  logic                     tall_spr_i,
    input  logic [NUM_SPR*TILE_W-1:0] spr_tile_i,
    input  logic [NUM_SPR*SROW_W-1:0] spr_row_i,
    input  logic [NUM_SPR-1:0]       spr_valid_i,
    output logic [VADDR_W-1:0]       addr_o
);

    logic [TILE_W-1:0] slot_tile [NUM_SPR];
    logic [SROW_W-1:0] slot_row  [NUM_SPR];

    for (genvar i = 0; i < NUM_SPR; i++) begin : g_slot
        assign slot_tile[i] = spr_valid_i[i] ? spr_tile_i[TILE_W*i +: TILE_W] : EMPTY_TILE;
        assign slot_row[i]  = spr_valid_i[i] ? spr_row_i[SROW_W*i +: SROW_W] : '0;
    end

    logic [TILE_W-1:0] sel_tile;
    logic [SROW_W-1:0] sel_row;
    logic              spr_hi;
    logic [TILE_W-1:0] spr_tidx;

    always_comb begin
        sel_tile = slot_tile[spr_idx_i];
        sel_row  = slot_row[spr_idx_i];
        spr_hi   = tall_spr_i ? sel_tile[0] : spr_half_i;
        spr_tidx = tall_spr_i ? {sel_tile[TILE_W-1:1], sel_row[SROW_W-1]} : sel_tile;
        case (kind_i)
            FK_NAME, FK_SPR_DUMMY:
                addr_o = {2'b10, nt_ptr_i};
            FK_ATTR:
                addr_o = {2'b10, nt_ptr_i[11:10], 4'b1111, nt_ptr_i[9:7], nt_ptr_i[4:2]};
            FK_BG_PAT:
                addr_o = {1'b0, bg_half_i, bg_tile_i, plane_i, fine_y_i};
            FK_SPR_PAT:
                addr_o = {1'b0, spr_hi, spr_tidx, plane_i, sel_row[FINE_W-1:0]};
            default:
                addr_o = '0;
        endcase
    end

endmodule

// File: rtl/pattern_fetch_seq.sv
module pattern_fetch_seq
    import fetchseq_pkg::*;
#(
    parameter int unsigned DOT_W      = 9,
    parameter int unsigned LINE_DOTS  = 341,
    parameter int unsigned BG_GROUPS  = 32,
    parameter int unsigned NUM_SPR    = 8,
    parameter int unsigned PRE_GROUPS = 2,
    parameter int unsigned TAIL_FETCH = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [DOT_W-1:0]          dot_i,
    input  logic                      prerender_i,
    input  logic                      odd_frame_i,
    input  logic                      render_en_i,
    input  logic                      bg_half_i,
    input  logic                      spr_half_i,
    input  logic                      tall_spr_i,
    input  logic [NT_W-1:0]           nt_ptr_i,
    input  logic [TILE_W-1:0]         bg_tile_i,
    input  logic [FINE_W-1:0]         fine_y_i,
    input  logic [NUM_SPR*TILE_W-1:0] spr_tile_i,
    input  logic [NUM_SPR*SROW_W-1:0] spr_row_i,
    input  logic [NUM_SPR-1:0]        spr_valid_i,
    output logic [VADDR_W-1:0]        vaddr_o,
    output logic                      fetch_o,
    output logic                      a12_o,
    output logic                      line_last_o
);

    localparam int unsigned IDX_W = $clog2(NUM_SPR);
    localparam logic [DOT_W-1:0] LAST_DOT  = DOT_W'(LINE_DOTS - 1);
    localparam logic [DOT_W-1:0] SHORT_DOT = DOT_W'(LINE_DOTS - 2);

    fetch_kind_e        kind;
    logic               first_dot;
    logic               plane;
    logic [IDX_W-1:0]   spr_idx;
    logic [VADDR_W-1:0] new_addr;

    fetchseq_decode #(
        .DOT_W      (DOT_W),
        .BG_GROUPS  (BG_GROUPS),
        .SPR_GROUPS (NUM_SPR),
        .PRE_GROUPS (PRE_GROUPS),
        .TAIL_FETCH (TAIL_FETCH),
        .IDX_W      (IDX_W)
    ) u_decode (
        .dot_i     (dot_i),
        .kind_o    (kind),
        .first_o   (first_dot),
        .plane_o   (plane),
        .spr_idx_o (spr_idx)
    );

    fetchseq_addr #(
        .NUM_SPR (NUM_SPR),
        .IDX_W   (IDX_W)
    ) u_addr (
        .kind_i      (kind),
        .plane_i     (plane),
        .spr_idx_i   (spr_idx),
        .nt_ptr_i    (nt_ptr_i),
        .bg_tile_i   (bg_tile_i),
        .fine_y_i    (fine_y_i),
        .bg_half_i   (bg_half_i),
        .spr_half_i  (spr_half_i),
        .tall_spr_i  (tall_spr_i),
        .spr_tile_i  (spr_tile_i),
        .spr_row_i   (spr_row_i),
        .spr_valid_i (spr_valid_i),
        .addr_o      (new_addr)
    );

    seq_state_t st_d, st_q;
    logic       short_line;

    always_comb begin
        short_line   = prerender_i && odd_frame_i && render_en_i;
        st_d         = st_q;
        st_d.strobe  = 1'b0;
        st_d.line_last = (dot_i == LAST_DOT) || (short_line && dot_i == SHORT_DOT);
        if (render_en_i && first_dot && kind != FK_IDLE) begin
            st_d.addr   = new_addr;
            st_d.strobe = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign vaddr_o     = st_q.addr;
    assign fetch_o     = st_q.strobe;
    assign a12_o       = st_q.addr[12];
    assign line_last_o = st_q.line_last;

endmodule

// File: rtl/pattern_fetch_seq_chk.sv
module pattern_fetch_seq_chk #(
    parameter int unsigned DOT_W     = 9,
    parameter int unsigned LINE_DOTS = 341,
    parameter int unsigned TAIL_DOT  = 336
) (
    input logic             clk,
    input logic             rst_n,
    input logic [DOT_W-1:0] dot_i,
    input logic             prerender_i,
    input logic             odd_frame_i,
    input logic             render_en_i,
    input logic [13:0]      vaddr_o,
    input logic             fetch_o,
    input logic             a12_o,
    input logic             line_last_o
);

    // R9: no strobe after a dot presented with rendering off
    a_r9_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(render_en_i) |-> !fetch_o);

    // R2: strobes only follow even dots inside the fetch window
    a_r2_strobe_on_even: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_o |-> ($past(dot_i[0]) == 1'b0 && $past(dot_i) < DOT_W'(LINE_DOTS - 1)));

    // R11: nametable and attribute fetches keep bit 12 low
    a_r11_a12_low_on_name: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_o && ($past(dot_i) >= DOT_W'(TAIL_DOT) || $past(dot_i[2:1]) < 2'd2))
        |-> !a12_o);

    // R8: address only moves with a strobe
    a_r8_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
        !fetch_o |-> $stable(vaddr_o));

    // R10: line end flag follows the last dot of the line
    a_r10_line_end: assert property (@(posedge clk) disable iff (!rst_n)
        line_last_o |-> ($past(dot_i) == DOT_W'(LINE_DOTS - 1) ||
                         ($past(dot_i) == DOT_W'(LINE_DOTS - 2) &&
                          $past(prerender_i && odd_frame_i && render_en_i))));

endmodule

bind pattern_fetch_seq pattern_fetch_seq_chk #(
    .DOT_W     (DOT_W),
    .LINE_DOTS (LINE_DOTS),
    .TAIL_DOT  ((BG_GROUPS + NUM_SPR + PRE_GROUPS) * 8)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .dot_i       (dot_i),
    .prerender_i (prerender_i),
    .odd_frame_i (odd_frame_i),
    .render_en_i (render_en_i),
    .vaddr_o     (vaddr_o),
    .fetch_o     (fetch_o),
    .a12_o       (a12_o),
    .line_last_o (line_last_o)
);

// File: tb/pattern_fetch_seq_tb.sv
module pattern_fetch_seq_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [8:0]  dot_i = '0;
    logic        prerender_i = 1'b0, odd_frame_i = 1'b0, render_en_i = 1'b0;
    logic        bg_half_i = 1'b0, spr_half_i = 1'b0, tall_spr_i = 1'b0;
    logic [11:0] nt_ptr_i = '0;
    logic [7:0]  bg_tile_i = '0;
    logic [2:0]  fine_y_i = '0;
    logic [63:0] spr_tile_i = '0;
    logic [31:0] spr_row_i = '0;
    logic [7:0]  spr_valid_i = '0;
    logic [13:0] vaddr_o;
    logic        fetch_o, a12_o, line_last_o;

    int checks = 0;
    int failures = 0;
    int exp_addr = 0;
    int line_no = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    pattern_fetch_seq u_dut (
        .clk(clk), .rst_n(rst_n), .dot_i(dot_i), .prerender_i(prerender_i),
        .odd_frame_i(odd_frame_i), .render_en_i(render_en_i), .bg_half_i(bg_half_i),
        .spr_half_i(spr_half_i), .tall_spr_i(tall_spr_i), .nt_ptr_i(nt_ptr_i),
        .bg_tile_i(bg_tile_i), .fine_y_i(fine_y_i), .spr_tile_i(spr_tile_i),
        .spr_row_i(spr_row_i), .spr_valid_i(spr_valid_i), .vaddr_o(vaddr_o),
        .fetch_o(fetch_o), .a12_o(a12_o), .line_last_o(line_last_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s line=%0d dot=%0d actual=%0h expected=%0h",
                     req, line_no, dot_i, act, exp);
        end
    endtask

    // behavioural model of the fetch address for one dot
    function automatic int model_addr(input int d);
        int st, plane, ntp, slot, t, r, half, idx;
        st = (d % 8) / 2;
        plane = st - 2;
        ntp = int'(nt_ptr_i);
        if (d >= 336) return 'h2000 + ntp;
        if (d >= 256 && d < 320) begin
            if (st < 2) return 'h2000 + ntp;
            slot = (d - 256) / 8;
            t = spr_valid_i[slot] ? int'(spr_tile_i[slot*8 +: 8]) : 255;
            r = spr_valid_i[slot] ? int'(spr_row_i[slot*4 +: 4]) : 0;
            if (tall_spr_i) begin
                half = t % 2;
                idx = (t / 2) * 2 + r / 8;
            end else begin
                half = int'(spr_half_i);
                idx = t;
            end
            return half * 4096 + idx * 16 + plane * 8 + (r % 8);
        end
        if (st == 0) return 'h2000 + ntp;
        if (st == 1)
            return 'h23C0 + (ntp / 1024) * 1024 + ((ntp / 128) % 8) * 8 + ((ntp / 4) % 8);
        return int'(bg_half_i) * 4096 + int'(bg_tile_i) * 16 + plane * 8 + int'(fine_y_i);
    endfunction

    function automatic string addr_tag(input int d, input bit ren);
        int st;
        st = (d % 8) / 2;
        if (!ren) return "R9";
        if (d >= 340 || d % 2 == 1) return "R8";
        if (d >= 336) return "R7";
        if (d >= 256 && d < 320) begin
            if (st < 2) return "R4";
            if (tall_spr_i) return "R6";
            if (!spr_valid_i[(d - 256) / 8]) return "R5";
            return "R4";
        end
        return "R3";
    endfunction

    task automatic run_line(input bit bgh, input bit sph, input bit tall, input logic [7:0] mask,
                            input bit pre, input bit odd, input bit ren,
                            input int off_lo, input int off_hi);
        int ndots;
        ndots = (pre && odd && ren) ? 340 : 341;
        for (int d = 0; d < ndots; d++) begin
            bit ren_now, e_str, e_last, is_name;
            @(negedge clk);
            ren_now = ren && !(d >= off_lo && d < off_hi);
            dot_i = 9'(d);
            prerender_i = pre; odd_frame_i = odd; render_en_i = ren_now;
            bg_half_i = bgh; spr_half_i = sph; tall_spr_i = tall; spr_valid_i = mask;
            nt_ptr_i = 12'((d * 37 + line_no * 11) & 'hFFF);
            bg_tile_i = 8'((d * 13 + line_no * 7) & 255);
            fine_y_i = 3'((line_no + d / 64) % 8);
            for (int i = 0; i < 8; i++) begin
                spr_tile_i[i*8 +: 8] = 8'((line_no * 29 + i * 53 + 7) & 255);
                spr_row_i[i*4 +: 4] = 4'((line_no * 5 + i * 3) % 16);
            end
            e_str = ren_now && d < 340 && (d % 2 == 0);
            if (e_str) exp_addr = model_addr(d);
            e_last = (d == 340) || (d == 339 && pre && odd && ren_now);
            is_name = (d < 340) && (d >= 336 || ((d % 8) / 2) < 2);
            @(posedge clk);
            #1;
            chk(addr_tag(d, ren_now), int'(vaddr_o), exp_addr);
            chk(ren_now ? "R2" : "R9", int'(fetch_o), int'(e_str));
            chk(is_name ? "R11" : "R8", int'(a12_o), (exp_addr / 4096) % 2);
            chk("R10", int'(line_last_o), int'(e_last));
        end
        line_no++;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        checks++;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R1", int'(vaddr_o), 0);
        chk("R1", int'(fetch_o), 0);
        chk("R1", int'(a12_o), 0);
        chk("R1", int'(line_last_o), 0);
        @(negedge clk);
        rst_n = 1'b1;
        run_line(1'b0, 1'b1, 1'b0, 8'hFF, 1'b0, 1'b0, 1'b1, 0, 0);     // R3 R4 normal halves
        run_line(1'b1, 1'b0, 1'b0, 8'h5A, 1'b0, 1'b1, 1'b1, 0, 0);     // R5 swapped halves
        run_line(1'b0, 1'b0, 1'b1, 8'hF7, 1'b0, 1'b0, 1'b1, 0, 0);     // R6 8x16
        run_line(1'b1, 1'b1, 1'b1, 8'h3C, 1'b0, 1'b0, 1'b1, 0, 0);     // R6 R5 mixed
        run_line(1'b0, 1'b1, 1'b0, 8'hFF, 1'b1, 1'b1, 1'b1, 0, 0);     // R10 short line
        run_line(1'b0, 1'b1, 1'b0, 8'hFF, 1'b1, 1'b0, 1'b1, 0, 0);     // R10 full pre-render
        run_line(1'b1, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 100, 151); // R9 mid-line off
        run_line(1'b0, 1'b1, 1'b0, 8'hFF, 1'b1, 1'b1, 1'b0, 0, 0);     // R9 R10 fully off
        run_line(1'b1, 1'b0, 1'b1, 8'hA5, 1'b0, 1'b1, 1'b1, 0, 0);     // R7 R11 tall
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule